// File: doc/BRIEF.md
# Slot-Weighted Dispatch Group Tracker

This block sits beside an in-order instruction scheduler and keeps a running picture of the dispatch group being formed. The scheduler presents one candidate instruction per cycle. The candidate carries a scheduling class code, a branch flag, a record-form flag, its own tag, and up to two predecessor tags. Upstream logic has already filtered those predecessors: for a load they are ordering-dependent stores, and for a branch they are data-dependent counter-register writers. From this the tracker works out how many group slots the instruction costs and whether it has to open a new group. One cycle later it reports three things: a hint that another candidate should be preferred, a no-op hazard, and the number of padding no-ops needed.

When the scheduler commits an instruction (`issue`) or emits a no-op (`noop_emit`), the tracker updates its slot count, its branch count and its list of group members. A static input selects a machine that has a group-terminating no-op. In that mode a single no-op always closes the group.

Top module: `dg_dispatch_tracker`

## Requirements
- R1: A synchronous active-high reset clears the slot count, the branch count and every member entry. `prefer_another`, `noop_hazard` and `pad_count` read 0 after reset.
- R2: Slot cost by class code. Classes 1 (divide) and 2 (load/store with update) cost 2 slots. Classes 3 (indexed update), 4 (reserve / conditional store) and 5 (move to condition register) cost 4. Every other code, 0 and 6..15, costs 1.
- R3: A record-form instruction whose class cost is 1 is charged 2 slots. Record form does not change a cost of 2 or 4.
- R4: An instruction must lead a group when its final cost exceeds 1, or when its class is 6 (condition-register logical), 7 (move from condition register) or 8 (move to special register). `prefer_another` is registered, one cycle after a valid candidate that must lead while the slot count is nonzero.
- R5: An accepted issue adds the instruction's cost to the slot count, increments the branch count if it is a branch, and records its tag as a valid member. At most 6 members are kept and the branch count never exceeds 1.
- R6: An issue that arrives when the slot count is exactly 5, or a branch that arrives while one branch is already in the group, clears the group. The instruction itself is not recorded: the slot count becomes 0 and its tag never matches.
- R7: An instruction that must lead, issued while the slot count is nonzero, first clears the group and then is added. The slot count becomes its cost, and older members no longer match.
- R8: `noop_hazard` is asserted one cycle after a valid candidate that has taken no stall yet (`cand_first_try`=1) and whose valid predecessor tag equals the tag of a valid member.
- R9: `pad_count` is registered, one cycle after a valid candidate whose predecessor matches a member while fewer than 6 slots are used. Its value is 1 in terminating-no-op mode and 5 minus the slot count otherwise. In every other case it is 0. The stall flag does not affect it.
- R10: `noop_emit` clears the group in terminating-no-op mode or when the slot count is 6. Otherwise it adds one slot and one invalid member entry.
- R11: When `issue` and `noop_emit` are high together, only the issue takes effect. The slot count saturates at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_nop_mode | input | 1 | Static: group-terminating no-op available |
| cand_valid | input | 1 | Candidate fields are meaningful |
| cand_class | input | 4 | Scheduling class code |
| cand_branch | input | 1 | Candidate is a branch |
| cand_record | input | 1 | Candidate is a record-form instruction |
| cand_first_try | input | 1 | No stall has been taken for this candidate |
| cand_tag | input | 4 | Tag of the candidate, recorded on issue |
| cand_pred_tag | input | 8 | Two packed hazard-relevant predecessor tags |
| cand_pred_vld | input | 2 | Valid bits for the predecessor tags |
| issue | input | 1 | Commit the candidate into the group |
| noop_emit | input | 1 | A no-op is emitted this cycle |
| prefer_another | output | 1 | Registered hint: choose a different candidate |
| noop_hazard | output | 1 | Registered no-op hazard |
| pad_count | output | 3 | Registered number of padding no-ops |
| slots_used | output | 4 | Current slot count |
| branches_used | output | 2 | Current branch count |

## Verification
Two functions can land in the same cycle. The query of a candidate and the state update caused by issuing that same candidate, or by a no-op, can both happen on one edge. The bench holds `issue` high with a query active. It then expects the hint, hazard and pad outputs to reflect the slot count and members from before the edge, while `slots_used` already shows the state after it. The second case is `issue` and `noop_emit` raised together, where the slot count must grow by the instruction's cost alone. Tags issued on one edge are queried on the very next cycle, to show that a fresh member is visible at once.

// File: rtl/dg_pkg.sv
package dg_pkg;
  localparam int CLS_W  = 4;
  localparam int COST_W = 3;

  typedef logic [CLS_W-1:0] cls_t;

  localparam cls_t CLS_PLAIN     = 4'd0;
  localparam cls_t CLS_DIV       = 4'd1;
  localparam cls_t CLS_LSUPD     = 4'd2;
  localparam cls_t CLS_LSIDXUPD  = 4'd3;
  localparam cls_t CLS_RESV      = 4'd4;
  localparam cls_t CLS_MTCOND    = 4'd5;
  localparam cls_t CLS_CRLOGIC   = 4'd6;
  localparam cls_t CLS_MFCOND    = 4'd7;
  localparam cls_t CLS_MTSPECIAL = 4'd8;

  typedef struct packed {
    logic [COST_W-1:0] cost;
    logic              lead;
  } slot_info_t;
endpackage

// File: rtl/dg_cost_decode.sv
module dg_cost_decode
  import dg_pkg::*;
(
  input  cls_t       cls,
  input  logic       record_form,
  output slot_info_t info
);
  logic [COST_W-1:0] base_cost;
  logic              class_lead;

  always_comb begin
    case (cls)
      CLS_DIV, CLS_LSUPD:                   base_cost = COST_W'(2);
      CLS_LSIDXUPD, CLS_RESV, CLS_MTCOND:   base_cost = COST_W'(4);
      default:                              base_cost = COST_W'(1);
    endcase
    case (cls)
      CLS_CRLOGIC, CLS_MFCOND, CLS_MTSPECIAL: class_lead = 1'b1;
      default:                                class_lead = 1'b0;
    endcase
  end

  always_comb begin
    info.cost = (record_form && base_cost == COST_W'(1)) ? COST_W'(2) : base_cost;
    info.lead = class_lead || (info.cost > COST_W'(1));
  end
endmodule

// File: rtl/dg_member_list.sv
module dg_member_list #(
  parameter int MEMBERS = 6,
  parameter int TAG_W   = 4,
  parameter int NPRED   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   push,
  input  logic                   push_real,
  input  logic [TAG_W-1:0]       push_tag,
  input  logic [NPRED*TAG_W-1:0] pred_tag,
  input  logic [NPRED-1:0]       pred_vld,
  output logic                   hit
);
  localparam int CNT_W = $clog2(MEMBERS + 1);

  logic [TAG_W-1:0] ent_tag [MEMBERS];
  logic [MEMBERS-1:0] ent_vld;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= push ? CNT_W'(1) : '0;
    end else if (push && cnt < CNT_W'(MEMBERS)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < MEMBERS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_vld[i] <= 1'b0;
        ent_tag[i] <= '0;
      end else if (clear) begin
        if (i == 0 && push) begin
          ent_vld[i] <= push_real;
          ent_tag[i] <= push_tag;
        end else begin
          ent_vld[i] <= 1'b0;
        end
      end else if (push && cnt == CNT_W'(i)) begin
        ent_vld[i] <= push_real;
        ent_tag[i] <= push_tag;
      end
    end
  end

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < NPRED; p++) begin
      for (int i = 0; i < MEMBERS; i++) begin
        if (pred_vld[p] && ent_vld[i] && ent_tag[i] == pred_tag[p*TAG_W +: TAG_W])
          hit = 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MEMBERS)); // R5
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (clear && !push) |=> (ent_vld == '0)); // R6
endmodule

// File: rtl/dg_group_state.sv
module dg_group_state
  import dg_pkg::*;
#(
  parameter int FULL_SLOTS = 5,
  parameter int SLOT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              term_nop_mode,
  input  logic              issue,
  input  logic              noop_emit,
  input  logic              is_branch,
  input  slot_info_t        info,
  output logic [SLOT_W-1:0] slots,
  output logic [1:0]        branches,
  output logic              list_clear,
  output logic              list_push,
  output logic              list_push_real
);
  localparam logic [SLOT_W-1:0] FULL_V  = SLOT_W'(FULL_SLOTS);
  localparam logic [SLOT_W-1:0] LIMIT_V = SLOT_W'(FULL_SLOTS + 1);
  localparam logic [SLOT_W:0]   MAX_V   = {1'b0, {SLOT_W{1'b1}}};

  logic [SLOT_W-1:0] slots_nx;
  logic [1:0]        br_nx;
  logic [SLOT_W-1:0] base;
  logic [SLOT_W:0]   sum;
  logic              restart;

  always_comb begin
    slots_nx       = slots;
    br_nx          = branches;
    list_clear     = 1'b0;
    list_push      = 1'b0;
    list_push_real = 1'b0;
    restart        = info.lead && (slots != '0);
    base           = restart ? '0 : slots;
    sum            = '0;
    if (issue) begin
      if (slots == FULL_V || (is_branch && branches == 2'd1)) begin
        slots_nx   = '0;
        br_nx      = '0;
        list_clear = 1'b1;
      end else begin
        sum            = {1'b0, base} + (SLOT_W+1)'(info.cost);
        slots_nx       = (sum > MAX_V) ? MAX_V[SLOT_W-1:0] : sum[SLOT_W-1:0];
        br_nx          = (restart ? 2'd0 : branches) + {1'b0, is_branch};
        list_clear     = restart;
        list_push      = 1'b1;
        list_push_real = 1'b1;
      end
    end else if (noop_emit) begin
      if (term_nop_mode || slots == LIMIT_V) begin
        slots_nx   = '0;
        br_nx      = '0;
        list_clear = 1'b1;
      end else begin
        sum       = {1'b0, slots} + (SLOT_W+1)'(1);
        slots_nx  = (sum > MAX_V) ? MAX_V[SLOT_W-1:0] : sum[SLOT_W-1:0];
        list_push = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slots    <= '0;
      branches <= '0;
    end else begin
      slots    <= slots_nx;
      branches <= br_nx;
    end
  end

  AST_BRANCH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    branches <= 2'd1); // R5
  AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (issue && slots == FULL_V) |=> (slots == '0)); // R6
  AST_LEAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    (issue && slots != FULL_V && !(is_branch && branches == 2'd1) && info.lead)
      |=> (slots == SLOT_W'($past(info.cost)))); // R7
  AST_NOOP_TERM: assert property (@(posedge clk) disable iff (rst)
    (noop_emit && !issue && term_nop_mode) |=> (slots == '0)); // R10
endmodule

// File: rtl/dg_dispatch_tracker.sv
module dg_dispatch_tracker
  import dg_pkg::*;
#(
  parameter int FULL_SLOTS = 5,
  parameter int SLOT_W     = 4,
  parameter int TAG_W      = 4,
  parameter int NPRED      = 2,
  parameter int PAD_W      = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   term_nop_mode,
  input  logic                   cand_valid,
  input  logic [3:0]             cand_class,
  input  logic                   cand_branch,
  input  logic                   cand_record,
  input  logic                   cand_first_try,
  input  logic [TAG_W-1:0]       cand_tag,
  input  logic [NPRED*TAG_W-1:0] cand_pred_tag,
  input  logic [NPRED-1:0]       cand_pred_vld,
  input  logic                   issue,
  input  logic                   noop_emit,
  output logic                   prefer_another,
  output logic                   noop_hazard,
  output logic [PAD_W-1:0]       pad_count,
  output logic [SLOT_W-1:0]      slots_used,
  output logic [1:0]             branches_used
);
  localparam int MEMBERS = FULL_SLOTS + 1;
  localparam logic [SLOT_W-1:0] FULL_V  = SLOT_W'(FULL_SLOTS);
  localparam logic [SLOT_W-1:0] LIMIT_V = SLOT_W'(FULL_SLOTS + 1);

  slot_info_t info;
  logic       dep_hit;
  logic       lst_clear, lst_push, lst_real;
  logic       pref_nx, haz_nx;
  logic [PAD_W-1:0] pad_nx;
  logic [SLOT_W-1:0] slots_q;

  dg_cost_decode u_decode (
    .cls         (cls_t'(cand_class)),
    .record_form (cand_record),
    .info        (info)
  );

  dg_group_state #(.FULL_SLOTS(FULL_SLOTS), .SLOT_W(SLOT_W)) u_state (
    .clk            (clk),
    .rst            (rst),
    .term_nop_mode  (term_nop_mode),
    .issue          (issue),
    .noop_emit      (noop_emit),
    .is_branch      (cand_branch),
    .info           (info),
    .slots          (slots_q),
    .branches       (branches_used),
    .list_clear     (lst_clear),
    .list_push      (lst_push),
    .list_push_real (lst_real)
  );

  dg_member_list #(.MEMBERS(MEMBERS), .TAG_W(TAG_W), .NPRED(NPRED)) u_members (
    .clk       (clk),
    .rst       (rst),
    .clear     (lst_clear),
    .push      (lst_push),
    .push_real (lst_real),
    .push_tag  (cand_tag),
    .pred_tag  (cand_pred_tag),
    .pred_vld  (cand_pred_vld),
    .hit       (dep_hit)
  );

  assign slots_used = slots_q;

  always_comb begin
    pref_nx = cand_valid && info.lead && (slots_q != '0);
    haz_nx  = cand_valid && cand_first_try && dep_hit;
    pad_nx  = '0;
    if (cand_valid && dep_hit && slots_q < LIMIT_V)
      pad_nx = term_nop_mode ? PAD_W'(1) : PAD_W'(FULL_V - slots_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prefer_another <= 1'b0;
      noop_hazard    <= 1'b0;
      pad_count      <= '0;
    end else begin
      prefer_another <= pref_nx;
      noop_hazard    <= haz_nx;
      pad_count      <= pad_nx;
    end
  end

  AST_PAD_RANGE: assert property (@(posedge clk) disable iff (rst)
    pad_count <= PAD_W'(FULL_SLOTS)); // R9
  AST_HAZ_FIRST_TRY: assert property (@(posedge clk) disable iff (rst)
    noop_hazard |-> $past(cand_first_try && cand_valid)); // R8
  AST_PREF_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    prefer_another |-> ($past(slots_q) != '0)); // R4
  AST_TERM_PAD_ONE: assert property (@(posedge clk) disable iff (rst)
    (term_nop_mode && pad_count != '0) |-> (pad_count == PAD_W'(1))); // R9
endmodule

// File: tb/dg_dispatch_tracker_tb.sv
module dg_dispatch_tracker_tb;
  logic clk = 1'b0;
  logic rst;
  logic term_nop_mode;
  logic cand_valid, cand_branch, cand_record, cand_first_try;
  logic [3:0] cand_class, cand_tag;
  logic [7:0] cand_pred_tag;
  logic [1:0] cand_pred_vld;
  logic issue, noop_emit;
  logic prefer_another, noop_hazard;
  logic [2:0] pad_count;
  logic [3:0] slots_used;
  logic [1:0] branches_used;

  int checks = 0;
  int errors = 0;

  int m_slots, m_br, m_cnt;
  int m_tag [6];
  bit m_v [6];

  always #5 clk = ~clk;

  dg_dispatch_tracker u_dut (
    .clk(clk), .rst(rst), .term_nop_mode(term_nop_mode),
    .cand_valid(cand_valid), .cand_class(cand_class), .cand_branch(cand_branch),
    .cand_record(cand_record), .cand_first_try(cand_first_try), .cand_tag(cand_tag),
    .cand_pred_tag(cand_pred_tag), .cand_pred_vld(cand_pred_vld),
    .issue(issue), .noop_emit(noop_emit),
    .prefer_another(prefer_another), .noop_hazard(noop_hazard), .pad_count(pad_count),
    .slots_used(slots_used), .branches_used(branches_used)
  );

  function automatic int m_cost(int c, bit rec);
    int b;
    if (c == 1 || c == 2) b = 2;
    else if (c >= 3 && c <= 5) b = 4;
    else b = 1;
    if (rec && b == 1) b = 2;
    return b;
  endfunction

  function automatic bit m_lead(int c, bit rec);
    return (m_cost(c, rec) > 1) || (c >= 6 && c <= 8);
  endfunction

  function automatic bit m_hit();
    bit h = 0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 6; i++)
        if (cand_pred_vld[p] && m_v[i] && m_tag[i] == int'(cand_pred_tag[p*4 +: 4])) h = 1;
    return h;
  endfunction

  task automatic m_clear();
    m_slots = 0; m_br = 0; m_cnt = 0;
    for (int i = 0; i < 6; i++) begin m_v[i] = 0; m_tag[i] = 0; end
  endtask

  task automatic m_push(int t, bit real_e);
    if (m_cnt < 6) begin m_tag[m_cnt] = t; m_v[m_cnt] = real_e; m_cnt++; end
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cand_valid = 0; cand_class = 0; cand_branch = 0; cand_record = 0;
    cand_first_try = 1; cand_tag = 0; cand_pred_tag = 0; cand_pred_vld = 0;
    issue = 0; noop_emit = 0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 0;
    m_clear();
  endtask

  task automatic step(string req);
    int e_pref, e_haz, e_pad, c;
    bit h;
    c = m_cost(int'(cand_class), cand_record);
    h = m_hit();
    e_pref = (cand_valid && m_lead(int'(cand_class), cand_record) && m_slots != 0) ? 1 : 0;
    e_haz  = (cand_valid && cand_first_try && h) ? 1 : 0;
    e_pad  = 0;
    if (cand_valid && h && m_slots < 6) e_pad = term_nop_mode ? 1 : 5 - m_slots;
    if (issue) begin
      if (m_slots == 5 || (cand_branch && m_br == 1)) m_clear();
      else begin
        if (m_lead(int'(cand_class), cand_record) && m_slots != 0) m_clear();
        m_slots = (m_slots + c > 15) ? 15 : m_slots + c;
        m_br += cand_branch;
        m_push(int'(cand_tag), 1);
      end
    end else if (noop_emit) begin
      if (term_nop_mode || m_slots == 6) m_clear();
      else begin
        m_slots = (m_slots + 1 > 15) ? 15 : m_slots + 1;
        m_push(0, 0);
      end
    end
    @(posedge clk); #1;
    check(req, "prefer_another", int'(prefer_another), e_pref);
    check(req, "noop_hazard", int'(noop_hazard), e_haz);
    check(req, "pad_count", int'(pad_count), e_pad);
    check(req, "slots_used", int'(slots_used), m_slots);
    check(req, "branches_used", int'(branches_used), m_br);
  endtask

  task automatic do_issue(int cls, bit br, bit rec, int tag, string req);
    idle(); cand_valid = 1; cand_class = 4'(cls); cand_branch = br;
    cand_record = rec; cand_tag = 4'(tag); issue = 1;
    step(req);
  endtask

  task automatic do_noop(string req);
    idle(); noop_emit = 1;
    step(req);
  endtask

  task automatic do_query(int cls, int ptag, bit first_try, string req);
    idle(); cand_valid = 1; cand_class = 4'(cls); cand_first_try = first_try;
    cand_pred_tag = {4'd0, 4'(ptag)}; cand_pred_vld = 2'b01;
    step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    term_nop_mode = 0;
    do_reset();
    // R1: reset state
    check("R1", "prefer_another", int'(prefer_another), 0);
    check("R1", "noop_hazard", int'(noop_hazard), 0);
    check("R1", "pad_count", int'(pad_count), 0);
    check("R1", "slots_used", int'(slots_used), 0);
    check("R1", "branches_used", int'(branches_used), 0);

    // R2 R3 R4: sweep every class, record and branch combination
    for (int cls = 0; cls < 16; cls++)
      for (int rec = 0; rec < 2; rec++)
        for (int br = 0; br < 2; br++) begin
          do_reset();
          do_issue(cls, br[0], rec[0], 1, "R2");
          idle(); cand_valid = 1; cand_class = 4'(cls); cand_record = rec[0];
          step("R4");
        end

    // R6: second branch clears, and the branch is not recorded
    do_reset();
    do_issue(0, 1, 0, 2, "R5");
    do_issue(0, 0, 0, 3, "R5");
    do_issue(0, 1, 0, 4, "R6");
    do_query(0, 4, 1, "R6");

    // R6: issue at slot count 5 clears; dropped tag must not match
    do_reset();
    for (int k = 0; k < 5; k++) do_issue(9, 0, 0, k, "R5");
    do_issue(0, 0, 0, 12, "R6");
    do_query(0, 12, 1, "R6");

    // R7: leading instruction clears older members
    do_reset();
    do_issue(0, 0, 0, 1, "R5");
    do_issue(1, 0, 0, 2, "R7");
    do_query(0, 1, 1, "R7");
    do_query(0, 2, 1, "R7");

    // R8: stall flag gates hazard but not pad count (R9)
    do_reset();
    do_issue(0, 0, 0, 7, "R5");
    do_query(0, 7, 0, "R8");
    do_query(0, 7, 1, "R8");
    idle(); cand_valid = 1; cand_pred_tag = {4'd7, 4'd3}; cand_pred_vld = 2'b10;
    step("R8");
    idle(); cand_valid = 0; cand_pred_tag = {4'd7, 4'd7}; cand_pred_vld = 2'b11;
    step("R8");

    // R9 R10: pad sweep across slot counts in plain mode
    for (int k = 1; k <= 7; k++) begin
      do_reset();
      do_issue(0, 0, 0, 5, "R9");
      for (int n = 1; n < k; n++) do_noop("R10");
      do_query(0, 5, 1, "R9");
    end

    // R9 R10: terminating-no-op mode
    term_nop_mode = 1;
    for (int k = 1; k <= 5; k++) begin
      do_reset();
      for (int n = 0; n < k; n++) do_issue(0, 0, 0, 6, "R9");
      do_query(0, 6, 1, "R9");
      do_noop("R10");
      do_query(0, 6, 1, "R10");
    end
    term_nop_mode = 0;

    // R11: issue and no-op together; saturation at 15
    do_reset();
    do_issue(0, 0, 0, 1, "R5");
    idle(); cand_valid = 1; cand_class = 4'd3; cand_tag = 4'd8; issue = 1; noop_emit = 1;
    step("R11");
    idle(); cand_valid = 1; cand_class = 4'd0; cand_tag = 4'd9; issue = 1; noop_emit = 1;
    cand_pred_tag = 8'h08; cand_pred_vld = 2'b01;
    step("R11");
    do_reset();
    do_issue(0, 0, 0, 1, "R11");
    for (int n = 0; n < 5; n++) do_noop("R11");
    for (int n = 0; n < 12; n++) do_issue(0, 0, 0, 2, "R11");
    do_query(0, 1, 1, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule